// File: doc/BRIEF.md
# DMA Stream Pattern Match Terminator

This block sits beside one DMA channel and watches the bytes that channel moves. When a programmed pattern of one or two bytes appears in the stream, it issues a one-clock terminate request that ends the current block or linked-list transfer. An optional "skip" byte value can be declared don't care, so that bytes with that value can fall between, or ahead of, pattern bytes without breaking a match.

The pattern bytes and the skip value live in one 32-bit configuration word, which is written and read through a plain register port. The word is frozen while the channel is enabled. Two level controls from the channel select the pattern length and enable the skip byte.

Matching runs only while the channel is enabled, and only on bytes marked by the valid strobe. In two-byte mode, a hit on the first pattern byte arms a one-deep state. The next byte that is not skipped either completes the match or drops the state. If that byte equals the first pattern byte, it arms the state again.

Top module: `pmt_terminator`

## Requirements
- R1: The configuration readback is {skip value in bits 31:24, 8'h00 in bits 23:16, second pattern byte in bits 15:8, first pattern byte in bits 7:0}. Bits 23:16 are not stored and always read as zero, even after writing ones there.
- R2: Synchronous reset clears the configuration word to 0x00000000 and holds the terminate output low.
- R3: A configuration write made while `chan_en` is 1 is discarded, and the readback keeps its previous value.
- R4: With `pat_two` = 1, a terminate needs the first pattern byte followed by the second pattern byte, as consecutive accepted bytes that are not skipped. The reverse order does not terminate.
- R5: With `pat_two` = 0, any accepted byte equal to the first pattern byte terminates on its own.
- R6: In two-byte mode, an armed state followed by a non-skipped byte that is not the second pattern byte is cleared. If that byte equals the first pattern byte, the state is armed again instead.
- R7: With `skip_en` = 1, an accepted byte equal to the skip value leaves the match state unchanged and causes no terminate. This test takes priority over pattern comparison. With `skip_en` = 0, such a byte is compared normally.
- R8: `term_pulse` is high for exactly one clock, in the cycle after the completing byte is accepted. The match state clears on a terminate and whenever `chan_en` is 0.
- R9: Only bytes with `byte_vld` = 1 while `chan_en` = 1 are evaluated. Any other byte causes no terminate and no state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_data | output | 32 | Configuration readback |
| chan_en | input | 1 | Channel enable; locks writes and gates matching |
| pat_two | input | 1 | 1 = two-byte pattern, 0 = one-byte pattern |
| skip_en | input | 1 | Treat bytes equal to the skip value as don't care |
| byte_vld | input | 1 | Byte valid strobe |
| byte_dat | input | 8 | Byte moved by the channel |
| term_pulse | output | 1 | One-clock terminate request |

## Verification
The assertions check several properties on every cycle:
- the reserved field reads as zero;
- the configuration word holds still while the channel is enabled, and an unlocked write lands with the right field layout;
- a terminate is always traceable to an enabled, valid byte in the previous cycle;
- a skip byte never causes a terminate;
- in one-byte mode, a first-byte hit always terminates.

The sequence-dependent behaviour can only be shown by the bench's scenarios. This covers ordering of the two bytes, re-arming on a repeated first byte, skip bytes falling between pattern bytes, and clearing of an armed state by a channel disable or by a completed match.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CFG_W    = 4 * BYTE_W;
  localparam int unsigned NUM_PAT  = 2;
  localparam int unsigned PAT0_LSB = 0;
  localparam int unsigned PAT1_LSB = BYTE_W;
  localparam int unsigned RSV_LSB  = 2 * BYTE_W;
  localparam int unsigned SKIP_LSB = 3 * BYTE_W;

  typedef struct packed {
    logic [BYTE_W-1:0] skip;
    logic [BYTE_W-1:0] pat1;
    logic [BYTE_W-1:0] pat0;
  } pmt_cfg_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } pmt_state_t;

  function automatic pmt_cfg_t cfg_from_word(input logic [CFG_W-1:0] w);
    pmt_cfg_t c;
    c.skip = w[SKIP_LSB +: BYTE_W];
    c.pat1 = w[PAT1_LSB +: BYTE_W];
    c.pat0 = w[PAT0_LSB +: BYTE_W];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] word_from_cfg(input pmt_cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[SKIP_LSB +: BYTE_W] = c.skip;
    w[PAT1_LSB +: BYTE_W] = c.pat1;
    w[PAT0_LSB +: BYTE_W] = c.pat0;
    return w;
  endfunction
endpackage

// File: rtl/pmt_cfg_reg.sv
module pmt_cfg_reg
  import pmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             lock,
  output pmt_cfg_t         cfg,
  output logic [CFG_W-1:0] rd_data
);
  pmt_cfg_t cfg_q;

  // Stored fields only; the reserved byte has no flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en && !lock) begin
      cfg_q <= cfg_from_word(wr_data);
    end
  end

  assign cfg     = cfg_q;
  assign rd_data = word_from_cfg(cfg_q);
endmodule

// File: rtl/pmt_byte_cmp.sv
module pmt_byte_cmp
  import pmt_pkg::*;
(
  input  logic [BYTE_W-1:0] dat,
  input  pmt_cfg_t          cfg,
  input  logic              skip_en,
  output logic [NUM_PAT-1:0] hit,
  output logic              skip
);
  logic [NUM_PAT-1:0][BYTE_W-1:0] pats;

  assign pats[0] = cfg.pat0;
  assign pats[1] = cfg.pat1;

  for (genvar i = 0; i < NUM_PAT; i++) begin : g_cmp
    assign hit[i] = (dat == pats[i]);
  end

  assign skip = skip_en && (dat == cfg.skip);
endmodule

// File: rtl/pmt_seq.sv
module pmt_seq
  import pmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               vld,
  input  logic               two,
  input  logic [NUM_PAT-1:0] hit,
  input  logic               skip,
  output logic               term
);
  pmt_state_t state_q, state_d;
  logic       fire;
  logic       term_q;

  always_comb begin
    state_d = state_q;
    fire    = 1'b0;
    if (!run) begin
      state_d = ST_IDLE;
    end else if (vld && !skip) begin
      if (!two) begin
        fire    = hit[0];
        state_d = ST_IDLE;
      end else if (state_q == ST_ARMED && hit[1]) begin
        fire    = 1'b1;
        state_d = ST_IDLE;
      end else begin
        state_d = hit[0] ? ST_ARMED : ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      term_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      term_q  <= fire;
    end
  end

  assign term = term_q;
endmodule

// File: rtl/pmt_terminator.sv
module pmt_terminator
  import pmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  output logic [CFG_W-1:0]  cfg_rd_data,
  input  logic              chan_en,
  input  logic              pat_two,
  input  logic              skip_en,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  output logic              term_pulse
);
  pmt_cfg_t           cfg;
  logic [NUM_PAT-1:0] hit;
  logic               skip;

  pmt_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .lock    (chan_en),
    .cfg     (cfg),
    .rd_data (cfg_rd_data)
  );

  pmt_byte_cmp u_cmp (
    .dat     (byte_dat),
    .cfg     (cfg),
    .skip_en (skip_en),
    .hit     (hit),
    .skip    (skip)
  );

  pmt_seq u_seq (
    .clk  (clk),
    .rst  (rst),
    .run  (chan_en),
    .vld  (byte_vld),
    .two  (pat_two),
    .hit  (hit),
    .skip (skip),
    .term (term_pulse)
  );
endmodule

// File: rtl/pmt_terminator_chk.sv
module pmt_terminator_chk
  import pmt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr_en,
  input logic [CFG_W-1:0]  cfg_wr_data,
  input logic [CFG_W-1:0]  cfg_rd_data,
  input logic              chan_en,
  input logic              pat_two,
  input logic              skip_en,
  input logic              byte_vld,
  input logic [BYTE_W-1:0] byte_dat,
  input logic              term_pulse
);
  logic skip_hit;
  assign skip_hit = skip_en && (byte_dat == cfg_rd_data[SKIP_LSB +: BYTE_W]);

  assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_data[RSV_LSB +: BYTE_W] == '0);

  assert_write_layout_R1: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && !chan_en) |=>
      (cfg_rd_data[SKIP_LSB +: BYTE_W] == $past(cfg_wr_data[SKIP_LSB +: BYTE_W])) &&
      (cfg_rd_data[0 +: 2*BYTE_W] == $past(cfg_wr_data[0 +: 2*BYTE_W])));

  assert_locked_stable_R3: assert property (@(posedge clk) disable iff (rst)
    chan_en |=> $stable(cfg_rd_data));

  assert_single_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (chan_en && byte_vld && !pat_two && !skip_hit &&
     byte_dat == cfg_rd_data[PAT0_LSB +: BYTE_W]) |=> term_pulse);

  assert_skip_no_term_R7: assert property (@(posedge clk) disable iff (rst)
    (chan_en && byte_vld && skip_hit) |=> !term_pulse);

  assert_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !(chan_en && byte_vld) |=> !term_pulse);
endmodule

bind pmt_terminator pmt_terminator_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .chan_en     (chan_en),
  .pat_two     (pat_two),
  .skip_en     (skip_en),
  .byte_vld    (byte_vld),
  .byte_dat    (byte_dat),
  .term_pulse  (term_pulse)
);

// File: tb/tb_pmt_terminator.sv
module tb_pmt_terminator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        chan_en = 1'b0;
  logic        pat_two = 1'b0;
  logic        skip_en = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_dat = '0;
  logic        term_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmt_terminator dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .chan_en(chan_en), .pat_two(pat_two),
    .skip_en(skip_en), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .term_pulse(term_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, output logic t);
    byte_vld = 1'b1; byte_dat = b;
    @(negedge clk);
    t = term_pulse;
    byte_vld = 1'b0;
  endtask

  task automatic run3(input string req, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] c, input logic [2:0] exp);
    logic t;
    push(a, t); chk(req, {31'd0, t}, {31'd0, exp[2]});
    push(b, t); chk(req, {31'd0, t}, {31'd0, exp[1]});
    push(c, t); chk(req, {31'd0, t}, {31'd0, exp[0]});
  endtask

  task automatic setup(input logic [31:0] cfg, input logic two, input logic sk);
    chan_en = 1'b0;
    @(negedge clk);
    wr_cfg(cfg);
    pat_two = two; skip_en = sk; chan_en = 1'b1;
  endtask

  task automatic t_reset;
    chk("R2 reset cfg", cfg_rd_data, 32'h0);
    chk("R2 reset term", {31'd0, term_pulse}, 32'h0);
  endtask

  task automatic t_layout;
    chan_en = 1'b0;
    wr_cfg(32'hFFFF_FFFF);
    chk("R1 reserved zero", cfg_rd_data, 32'hFF00_FFFF);
    wr_cfg(32'hEE12_C35A);
    chk("R1 field layout", cfg_rd_data, 32'hEE00_C35A);
  endtask

  task automatic t_lock;
    chan_en = 1'b1;
    @(negedge clk);
    wr_cfg(32'h1111_1111);
    chk("R3 write locked", cfg_rd_data, 32'hEE00_C35A);
    chan_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_single;
    setup(32'h0000_005A, 1'b0, 1'b0);
    run3("R5 single byte", 8'h11, 8'h5A, 8'h12, 3'b010);
    run3("R5 repeated hits", 8'h5A, 8'h5A, 8'h00, 3'b110);
  endtask

  task automatic t_two;
    setup(32'h0000_C35A, 1'b1, 1'b0);
    run3("R4 pair in order", 8'h00, 8'h5A, 8'hC3, 3'b001);
    run3("R4 reverse order", 8'hC3, 8'h5A, 8'h00, 3'b000);
    run3("R6 mismatch clears", 8'h5A, 8'h11, 8'hC3, 3'b000);
    run3("R6 rearm on first byte", 8'h5A, 8'h5A, 8'hC3, 3'b001);
  endtask

  task automatic t_skip;
    setup(32'hEE00_C35A, 1'b1, 1'b1);
    run3("R7 skip between", 8'h5A, 8'hEE, 8'hC3, 3'b001);
    setup(32'hEE00_C35A, 1'b1, 1'b0);
    run3("R7 skip disabled", 8'h5A, 8'hEE, 8'hC3, 3'b000);
    setup(32'h5A00_005A, 1'b0, 1'b1);
    run3("R7 skip has priority", 8'h5A, 8'h5A, 8'h00, 3'b000);
  endtask

  task automatic t_gate;
    logic t;
    setup(32'h0000_005A, 1'b0, 1'b0);
    chan_en = 1'b0;
    push(8'h5A, t);
    chk("R9 channel off", {31'd0, t}, 32'h0);
    chan_en = 1'b1;
    byte_dat = 8'h5A; byte_vld = 1'b0;
    @(negedge clk);
    chk("R9 no valid strobe", {31'd0, term_pulse}, 32'h0);
  endtask

  task automatic t_clear;
    logic t;
    setup(32'h0000_C35A, 1'b1, 1'b0);
    push(8'h5A, t);
    chan_en = 1'b0;
    @(negedge clk);
    chan_en = 1'b1;
    push(8'hC3, t);
    chk("R8 disable clears arm", {31'd0, t}, 32'h0);
    push(8'h5A, t);
    push(8'hC3, t);
    chk("R8 pulse after completing byte", {31'd0, t}, 32'h1);
    @(negedge clk);
    chk("R8 pulse one clock", {31'd0, term_pulse}, 32'h0);
    push(8'hC3, t);
    chk("R8 terminate clears state", {31'd0, t}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_lock();
    t_single();
    t_two();
    t_skip();
    t_gate();
    t_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule